// File: doc/BRIEF.md
# USB Path Monitor State Controller

This block is the control core of a two-port USB 2.0 re-driver. The line monitors reduce the bus to single-cycle event pulses and an SE0 level. From these the controller decides how the two ports are joined. One option is an analog pass-through switch, used for full-speed, low-speed and charger-detection traffic. The other is a high-speed retiming path, used while a high-speed link is up.

The controller has six states: reset, initial, disconnected, full/low-speed, high-speed and detach-hold. It leaves the timed states by counting cycles of the system clock. A strap selects whether a high-speed device detach passes through the detach-hold state. A force-through strap keeps the switch closed and the retimer idle in every state except reset. The connect enable is resynchronised by two flops before the state logic uses it.

Top module: `usb_path_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: `sw_on`=0, `rt_on`=0, `sw_chg_only`=0 and `state_code`=0.
- R2: The first clock edge after reset release enters the initial state. This state lasts `INIT_CYC` cycles with `sw_on`=1, `sw_chg_only`=1 and `state_code`=0. The block then enters the disconnected state.
- R3: The `conn_en` input takes effect three clock edges after it changes, because of a two-flop synchroniser. In the disconnected state, a synchronised `conn_en`=1 moves the block to full/low-speed (`state_code`=2). If the enable is already high, the block spends exactly one cycle in the disconnected state after the initial period.
- R4: In full/low-speed, a pulse on `hs_hshake_done` or on `hs_resume_done` moves the block to high-speed (`state_code`=3).
- R5: In high-speed, `se0_level` held high for `SE0_CYC` consecutive cycles returns the block to full/low-speed. A single low cycle restarts the count.
- R6: In high-speed, a `dev_detach` pulse with `detach_hold_en`=0 returns the block to full/low-speed.
- R7: In high-speed, a `dev_detach` pulse with `detach_hold_en`=1 enters the detach-hold state (`state_code`=1, switch and retimer both off). The block stays there `HOLD_CYC` cycles and then enters full/low-speed.
- R8: A synchronised `conn_en`=0 moves the block from full/low-speed, high-speed or detach-hold to the disconnected state (`state_code`=0). This exit takes priority over every other exit.
- R9: Without force-through, the outputs depend on the state as follows. In the disconnected and full/low-speed states the switch is on and the retimer is off. In high-speed the switch is off and the retimer is on. `sw_chg_only` is 1 only in the initial state.
- R10: With `force_thru`=1, `rt_on` is 0 in every state. `sw_on` is 1 in every state except reset. The state sequence itself is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (24 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_en | input | 1 | Connect enable, asynchronous to clk |
| detach_hold_en | input | 1 | Strap: route a high-speed detach through the hold state |
| force_thru | input | 1 | Strap: keep the switch closed and the retimer off |
| hs_hshake_done | input | 1 | Pulse: high-speed detection handshake finished |
| hs_resume_done | input | 1 | Pulse: high-speed resume finished |
| dev_detach | input | 1 | Pulse: detach level seen on the device-side port |
| se0_level | input | 1 | Current SE0 status of the bus |
| sw_on | output | 1 | Pass-through switch enable |
| sw_chg_only | output | 1 | Switch limited to charger-detection signalling |
| rt_on | output | 1 | High-speed retimer enable |
| state_code | output | 2 | 0 disconnected/initial/reset, 1 detach-hold, 2 full/low-speed, 3 high-speed |

## Verification
Some properties are checked by assertions on every cycle: the switch and retimer are never on together, force-through never lets the retimer run, the SE0 run counter never passes its limit, and loss of the enable always lands in the disconnected state. The strapped detach and the step out of reset are also covered by assertions. Other behaviour depends on a full history and is shown only by the bench scenarios: exact timer lengths, the restart of SE0 persistence after a short gap, the single disconnected cycle when the enable is already high, and the three-edge delay of the synchroniser. For these the bench compares the design against a behavioural model on every clock.

// File: rtl/usb_path_pkg.sv
package usb_path_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_INITIAL = 3'd1,
    ST_DISC    = 3'd2,
    ST_FSLS    = 3'd3,
    ST_HS      = 3'd4,
    ST_DETACH  = 3'd5
  } path_st_e;

  localparam logic [1:0] CODE_DISC   = 2'd0;
  localparam logic [1:0] CODE_DETACH = 2'd1;
  localparam logic [1:0] CODE_FSLS   = 2'd2;
  localparam logic [1:0] CODE_HS     = 2'd3;
endpackage

// File: rtl/upc_sync2.sv
module upc_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/upc_counter.sv
module upc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || inc) cnt <= cnt_d;
  end
endmodule

// File: rtl/upc_decode.sv
module upc_decode
  import usb_path_pkg::*;
(
  input  path_st_e   st,
  input  logic       force_thru,
  output logic       sw_on,
  output logic       sw_chg_only,
  output logic       rt_on,
  output logic [1:0] code
);
  logic sw_nat, rt_nat;

  always_comb begin
    sw_nat      = 1'b0;
    rt_nat      = 1'b0;
    sw_chg_only = 1'b0;
    code        = CODE_DISC;
    unique case (st)
      ST_RESET:   ;
      ST_INITIAL: begin sw_nat = 1'b1; sw_chg_only = 1'b1; end
      ST_DISC:    sw_nat = 1'b1;
      ST_FSLS:    begin sw_nat = 1'b1; code = CODE_FSLS; end
      ST_HS:      begin rt_nat = 1'b1; code = CODE_HS; end
      ST_DETACH:  code = CODE_DETACH;
      default:    ;
    endcase
  end

  assign sw_on = force_thru ? (st != ST_RESET) : sw_nat;
  assign rt_on = rt_nat && !force_thru;
endmodule

// File: rtl/usb_path_ctrl.sv
module usb_path_ctrl
  import usb_path_pkg::*;
#(
  parameter int INIT_CYC = 240000,
  parameter int HOLD_CYC = 72000,
  parameter int SE0_CYC  = 72000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conn_en,
  input  logic       detach_hold_en,
  input  logic       force_thru,
  input  logic       hs_hshake_done,
  input  logic       hs_resume_done,
  input  logic       dev_detach,
  input  logic       se0_level,
  output logic       sw_on,
  output logic       sw_chg_only,
  output logic       rt_on,
  output logic [1:0] state_code
);
  localparam int TMAX = (INIT_CYC > HOLD_CYC) ? INIT_CYC : HOLD_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int SW   = $clog2(SE0_CYC + 1);

  path_st_e        state_q, state_d;
  logic            conn_s;
  logic [TW-1:0]   age;
  logic [SW-1:0]   se0_run;
  logic            tmr_inc, st_chg, se0_inc;
  logic            init_done, hold_done, se0_done;

  upc_sync2 #(.STAGES(2)) u_conn_sync (
    .clk(clk), .rst_n(rst_n), .d(conn_en), .q(conn_s)
  );

  assign st_chg  = (state_d != state_q);
  assign tmr_inc = (state_q == ST_INITIAL) || (state_q == ST_DETACH);

  upc_counter #(.W(TW)) u_state_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st_chg), .inc(tmr_inc), .cnt(age)
  );

  assign se0_inc = (state_q == ST_HS) && se0_level;

  upc_counter #(.W(SW)) u_se0_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!se0_inc), .inc(se0_inc), .cnt(se0_run)
  );

  assign init_done = (age == TW'(INIT_CYC - 1));
  assign hold_done = (age == TW'(HOLD_CYC - 1));
  assign se0_done  = se0_inc && (se0_run == SW'(SE0_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:   state_d = ST_INITIAL;
      ST_INITIAL: if (init_done) state_d = ST_DISC;
      ST_DISC:    if (conn_s) state_d = ST_FSLS;
      ST_FSLS: begin
        if (!conn_s)                              state_d = ST_DISC;
        else if (hs_hshake_done || hs_resume_done) state_d = ST_HS;
      end
      ST_HS: begin
        if (!conn_s)         state_d = ST_DISC;
        else if (dev_detach) state_d = detach_hold_en ? ST_DETACH : ST_FSLS;
        else if (se0_done)   state_d = ST_FSLS;
      end
      ST_DETACH: begin
        if (!conn_s)        state_d = ST_DISC;
        else if (hold_done) state_d = ST_FSLS;
      end
      default:    state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  upc_decode u_decode (
    .st(state_q), .force_thru(force_thru), .sw_on(sw_on),
    .sw_chg_only(sw_chg_only), .rt_on(rt_on), .code(state_code)
  );

  // R9
  path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_on |-> !sw_on);

  // R10
  force_rt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_thru |-> !rt_on);

  // R2
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET) |=> (state_q == ST_INITIAL));

  // R7
  detach_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HS && conn_s && dev_detach && detach_hold_en)
      |=> (state_q == ST_DETACH));

  // R5
  se0_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    se0_run <= SW'(SE0_CYC));

  // R8
  conn_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conn_s && (state_q == ST_FSLS || state_q == ST_HS || state_q == ST_DETACH))
      |=> (state_q == ST_DISC));
endmodule

// File: tb/usb_path_ctrl_bench.sv
module usb_path_ctrl_bench;
  localparam int CLK_PER = 10;
  localparam int INIT_N  = 20;
  localparam int HOLD_N  = 8;
  localparam int SE0_N   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conn_en = 1'b0, detach_hold_en = 1'b0, force_thru = 1'b0;
  logic hs_hshake_done = 1'b0, hs_resume_done = 1'b0, dev_detach = 1'b0, se0_level = 1'b0;
  logic sw_on, sw_chg_only, rt_on;
  logic [1:0] state_code;

  int checks = 0;
  int failures = 0;

  always #(CLK_PER/2) clk = ~clk;

  usb_path_ctrl #(.INIT_CYC(INIT_N), .HOLD_CYC(HOLD_N), .SE0_CYC(SE0_N)) u_usb_path_ctrl (
    .clk(clk), .rst_n(rst_n), .conn_en(conn_en), .detach_hold_en(detach_hold_en),
    .force_thru(force_thru), .hs_hshake_done(hs_hshake_done),
    .hs_resume_done(hs_resume_done), .dev_detach(dev_detach), .se0_level(se0_level),
    .sw_on(sw_on), .sw_chg_only(sw_chg_only), .rt_on(rt_on), .state_code(state_code)
  );

  // Behavioural model: 0 reset, 1 initial, 2 disc, 3 fs/ls, 4 hs, 5 detach-hold
  int m_st = 0;
  int m_age = 0;
  int m_se0 = 0;
  int cq[$] = '{0, 0};

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int s, nst;
    int e_sw, e_chg, e_rt, e_code;
    string tag;
    if (!rst_n) begin
      m_st = 0; m_age = 0; m_se0 = 0; cq = '{0, 0};
    end else begin
      s = cq[0];
      void'(cq.pop_front());
      cq.push_back(int'(conn_en));
      nst = m_st;
      case (m_st)
        0: nst = 1;
        1: if (m_age == INIT_N - 1) nst = 2;
        2: if (s != 0) nst = 3;
        3: if (s == 0) nst = 2; else if (hs_hshake_done || hs_resume_done) nst = 4;
        4: if (s == 0) nst = 2;
           else if (dev_detach) nst = detach_hold_en ? 5 : 3;
           else if (se0_level && m_se0 == SE0_N - 1) nst = 3;
        5: if (s == 0) nst = 2; else if (m_age == HOLD_N - 1) nst = 3;
        default: nst = 0;
      endcase
      m_se0 = (m_st == 4 && se0_level) ? m_se0 + 1 : 0;
      m_age = (nst != m_st) ? 0 : m_age + 1;
      m_st  = nst;
    end
    #(CLK_PER/4);
    e_chg  = (m_st == 1);
    e_code = (m_st == 5) ? 1 : (m_st == 3) ? 2 : (m_st == 4) ? 3 : 0;
    if (force_thru) begin
      e_sw = (m_st != 0); e_rt = 0;
    end else begin
      e_sw = (m_st == 1 || m_st == 2 || m_st == 3); e_rt = (m_st == 4);
    end
    tag = force_thru ? "R10" : (m_st == 0) ? "R1" : (m_st == 1) ? "R2" : "R9";
    chk(tag, int'(sw_on), e_sw, "model sw_on");
    chk(tag, int'(sw_chg_only), e_chg, "model sw_chg_only");
    chk(tag, int'(rt_on), e_rt, "model rt_on");
    chk(tag, int'(state_code), e_code, "model state_code");
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; cyc(1); sig = 1'b0;
  endtask

  initial begin
    #(CLK_PER * 150000);
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1", int'(sw_on), 0, "sw_on in reset");
    chk("R1", int'(state_code), 0, "code in reset");
    rst_n = 1'b1;
    cyc(2);
    chk("R2", int'(sw_chg_only), 1, "charger-only flag in initial");
    cyc(INIT_N + 1);
    chk("R2", int'(sw_chg_only), 0, "flag cleared in disconnected");
    chk("R2", int'(sw_on), 1, "switch on in disconnected");
    conn_en = 1'b1;
    cyc(2);
    chk("R3", int'(state_code), 0, "enable still in synchroniser");
    cyc(2);
    chk("R3", int'(state_code), 2, "fs/ls after enable");
    pulse(hs_hshake_done);
    chk("R4", int'(state_code), 3, "hs after handshake");
    chk("R9", int'(rt_on), 1, "retimer on in hs");
    se0_level = 1'b1; cyc(3); se0_level = 1'b0; cyc(1);
    se0_level = 1'b1; cyc(SE0_N - 1);
    chk("R5", int'(state_code), 3, "hs before se0 limit");
    cyc(1); se0_level = 1'b0;
    chk("R5", int'(state_code), 2, "fs/ls after se0 run");
    pulse(hs_resume_done);
    chk("R4", int'(state_code), 3, "hs after resume");
    pulse(dev_detach);
    chk("R6", int'(state_code), 2, "fs/ls after detach, strap low");
    detach_hold_en = 1'b1;
    pulse(hs_hshake_done);
    pulse(dev_detach);
    chk("R7", int'(state_code), 1, "detach-hold entered");
    chk("R7", int'(sw_on), 0, "switch off in hold");
    cyc(HOLD_N - 1);
    chk("R7", int'(state_code), 1, "still holding");
    cyc(1);
    chk("R7", int'(state_code), 2, "fs/ls after hold");
    pulse(hs_hshake_done);
    conn_en = 1'b0;
    cyc(3);
    chk("R8", int'(state_code), 0, "disconnected after enable drop from hs");
    conn_en = 1'b1; cyc(4);
    pulse(hs_hshake_done); pulse(dev_detach);
    conn_en = 1'b0; cyc(3);
    chk("R8", int'(state_code), 0, "disconnected after enable drop from hold");
    // reset with enable and force already high
    force_thru = 1'b1; conn_en = 1'b1;
    rst_n = 1'b0; cyc(2);
    chk("R10", int'(sw_on), 0, "switch off in reset under force");
    rst_n = 1'b1; cyc(1);
    chk("R10", int'(sw_on), 1, "switch on in initial under force");
    cyc(INIT_N);
    chk("R3", int'(state_code), 0, "single disconnected cycle");
    cyc(1);
    chk("R3", int'(state_code), 2, "fs/ls right after initial");
    pulse(hs_hshake_done);
    chk("R10", int'(state_code), 3, "hs under force");
    chk("R10", int'(rt_on), 0, "retimer off under force");
    chk("R10", int'(sw_on), 1, "switch on under force");
    cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule